// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Detector

This block watches twelve general-purpose input pins and raises an interrupt when any selected pin changes level. Pins 0 to 7 belong to group 0 and pins 8 to 11 belong to group 1. Each group has its own per-pin select mask, a sticky flag, a clear strobe, an enable bit and an interrupt request. Both rising and falling transitions count. Because the pins are only observed, a pin that the rest of the chip drives as an output can still trigger its group, which lets software raise an interrupt on purpose.

Every pin first passes a latch that is open while the clock is low. A synchronizing flop and a history flop follow the latch. The two flops are compared, the result is masked and ORed per group, and a registered change pulse and then a flag-set pulse are produced before the flag itself. A separate combinational wake output compares the raw pins with their last synchronized values. It therefore goes high without any clock edge, so a power controller can restart a stopped clock from it.

The reset input is active low and asynchronous. It is expected to be released synchronously to `clk` by the surrounding reset logic.

Top module: `pin_toggle_irq`

## Requirements
- R1: After reset, `flag_o` and `irq_o` are 0. Pins that are held at any static level, including levels present during reset, never set a flag.
- R2: A toggle on any pin 0..7 whose bit is 1 in `mask0_i` sets `flag_o[0]` and leaves `flag_o[1]` unchanged.
- R3: A toggle on any pin 8..11 whose bit is 1 in `mask1_i` (pin 8 maps to bit 0) sets `flag_o[1]` and leaves `flag_o[0]` unchanged.
- R4: A toggle on a pin whose mask bit is 0 sets no flag and does not raise `wake_o`.
- R5: A pin change applied while `clk` is low sets the flag on the fourth rising edge after the change, and not earlier.
- R6: A flag stays at 1 until its `clr_i` bit is 1 on a rising edge. That edge clears it to 0.
- R7: When the flag-set pulse and `clr_i` land on the same rising edge, the flag ends at 1.
- R8: `irq_o[g]` equals `flag_o[g]` AND `en_i[g]`. The value of `en_i` has no effect on whether `flag_o` is set.
- R9: `wake_o` is 1, with no clock edge required, when some pin is selected in its mask, its group is enabled, and its level differs from its last synchronized value. `wake_o` falls once the synchronizer captures the new level.
- R10: Rising and falling transitions both count as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the pin latches are open while it is low |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Monitored pin levels |
| mask0_i | input | 8 | Per-pin select for group 0 (pins 0..7) |
| mask1_i | input | 4 | Per-pin select for group 1 (pins 8..11) |
| en_i | input | 2 | Per-group interrupt enable |
| clr_i | input | 2 | Per-group flag clear strobe |
| flag_o | output | 2 | Sticky per-group change flags |
| irq_o | output | 2 | Per-group interrupt requests |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The hardest case to reach is a clear strobe that falls exactly on the edge that carries the flag-set pulse. The bench reaches it by counting edges from a pin change made in the low phase and raising the clear during the low phase before the fourth edge. The asynchronous wake output is checked within the same low phase as the pin change, before any rising edge. Random rounds then combine random toggle patterns, masks and enables and compare the results with flags and wake values computed in the bench.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int NGRP = 2;
  typedef logic [NGRP-1:0] grp_vec_t;
endpackage

// File: rtl/pct_pin_stage.sv
module pct_pin_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic chg_o,
  output logic diff_o
);
  logic lat_q;
  logic sync_q, sync_d;
  logic prev_q, prev_d;

  // transparent during the low clock phase
  always_latch begin
    if (!clk) lat_q = pin_i;
  end

  always_comb begin
    sync_d = lat_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign chg_o  = sync_q ^ prev_q;
  assign diff_o = pin_i ^ sync_q;
endmodule

// File: rtl/pct_group_flag.sv
module pct_group_flag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic [W-1:0] chg_i,
  input  logic [W-1:0] diff_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic         set_o,
  output logic         flag_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic hit_d, syn_q;
  logic set_q;
  logic flag_q, flag_d, flag_en;

  always_comb begin
    hit_d   = arm_i & (|(chg_i & mask_i));
    flag_en = set_q | clr_i;
    flag_d  = set_q | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q  <= 1'b0;
      set_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      syn_q <= hit_d;
      set_q <= syn_q;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign set_o  = set_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
  assign wake_o = en_i & (|(diff_i & mask_i));
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import pct_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int G0_PINS  = 8,
  localparam int G1_PINS = NUM_PINS - G0_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [G0_PINS-1:0]  mask0_i,
  input  logic [G1_PINS-1:0]  mask1_i,
  input  logic [NGRP-1:0]     en_i,
  input  logic [NGRP-1:0]     clr_i,
  output logic [NGRP-1:0]     flag_o,
  output logic [NGRP-1:0]     irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] chg_w, diff_w;
  grp_vec_t set_w, wake_w;
  logic [1:0] arm_q, arm_d;

  // change detection starts once sync and history hold real pin levels
  always_comb arm_d = {arm_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 2'b00;
    else        arm_q <= arm_d;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pct_pin_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i[p]),
      .chg_o (chg_w[p]),
      .diff_o(diff_w[p])
    );
  end

  pct_group_flag #(.W(G0_PINS)) u_grp0 (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (arm_q[1]),
    .chg_i (chg_w[G0_PINS-1:0]),
    .diff_i(diff_w[G0_PINS-1:0]),
    .mask_i(mask0_i),
    .en_i  (en_i[0]),
    .clr_i (clr_i[0]),
    .set_o (set_w[0]),
    .flag_o(flag_o[0]),
    .irq_o (irq_o[0]),
    .wake_o(wake_w[0])
  );

  pct_group_flag #(.W(G1_PINS)) u_grp1 (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (arm_q[1]),
    .chg_i (chg_w[NUM_PINS-1:G0_PINS]),
    .diff_i(diff_w[NUM_PINS-1:G0_PINS]),
    .mask_i(mask1_i),
    .en_i  (en_i[1]),
    .clr_i (clr_i[1]),
    .set_o (set_w[1]),
    .flag_o(flag_o[1]),
    .irq_o (irq_o[1]),
    .wake_o(wake_w[1])
  );

  assign wake_o = |wake_w;
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int NGRP = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NGRP-1:0] flag,
  input logic [NGRP-1:0] irq,
  input logic [NGRP-1:0] clr,
  input logic [NGRP-1:0] set_pulse
);
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !clr[g]) |=> flag[g]);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !set_pulse[g]) |=> !flag[g]);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[g] |=> flag[g]);
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> flag[g]);
    a_r5_rise_after_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[g]) |-> $past(set_pulse[g]));
  end
endmodule

bind pin_toggle_irq pct_checker #(.NGRP(2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flag     (flag_o),
  .irq      (irq_o),
  .clr      (clr_i),
  .set_pulse(set_w)
);

// File: tb/pin_toggle_irq_test.sv
`timescale 1ns/100ps
module pin_toggle_irq_test;
  logic        clk;
  logic        rst_n;
  logic [11:0] pin_i;
  logic [7:0]  mask0_i;
  logic [3:0]  mask1_i;
  logic [1:0]  en_i, clr_i, flag_o, irq_o;
  logic        wake_o;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  pin_toggle_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mask0_i(mask0_i),
    .mask1_i(mask1_i), .en_i(en_i), .clr_i(clr_i), .flag_o(flag_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] exp_hit(logic [11:0] t, logic [7:0] m0, logic [3:0] m1);
    return {|(t[11:8] & m1), |(t[7:0] & m0)};
  endfunction

  function automatic logic exp_wake(logic [11:0] t, logic [7:0] m0, logic [3:0] m1, logic [1:0] en);
    return |(exp_hit(t, m0, m1) & en);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // change pins in the low phase; leaves time at negedge + 1 ns
  task automatic toggle(logic [11:0] t);
    @(negedge clk);
    #0.5 pin_i = pin_i ^ t;
    #0.5;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear(logic [1:0] c);
    @(negedge clk);
    clr_i = c;
    @(posedge clk);
    #1 clr_i = 2'b00;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] t;
    logic [1:0]  e;
    void'($urandom(32'd1234));
    rst_n = 1'b0; pin_i = 12'hA5C; mask0_i = 8'hFF; mask1_i = 4'hF;
    en_i = 2'b11; clr_i = 2'b00;
    step(3);
    check("R1 reset flag", flag_o, 2'b00);
    check("R1 reset irq", irq_o, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    step(6);
    check("R1 static pins no flag", flag_o, 2'b00);

    // R2 / R5 / R9 / R10 rising edge on pin 3
    toggle(12'h008);
    check("R9 wake before edge", wake_o, 1'b1);
    step(1);
    check("R9 wake drops after sync", wake_o, 1'b0);
    step(2);
    check("R5 not set on third edge", flag_o, 2'b00);
    step(1);
    check("R2 group0 set on fourth edge", flag_o, 2'b01);
    check("R8 irq follows flag", irq_o, 2'b01);
    step(5);
    check("R6 flag sticky", flag_o, 2'b01);
    clear(2'b01);
    check("R6 clear strobe", flag_o, 2'b00);

    // R10 falling edge on pin 3
    toggle(12'h008);
    step(4);
    check("R10 falling edge sets", flag_o, 2'b01);
    clear(2'b01);

    // R3 pin 10
    toggle(12'h400);
    check("R9 wake group1", wake_o, 1'b1);
    step(4);
    check("R3 group1 only", flag_o, 2'b10);
    clear(2'b10);

    // R4 masked pin 5
    mask0_i = 8'hDF;
    toggle(12'h020);
    check("R4 masked no wake", wake_o, 1'b0);
    step(6);
    check("R4 masked no flag", flag_o, 2'b00);
    mask0_i = 8'hFF;

    // R8 disabled group still flags
    en_i = 2'b10;
    toggle(12'h001);
    check("R9 disabled group no wake", wake_o, 1'b0);
    step(4);
    check("R8 flag without enable", flag_o, 2'b01);
    check("R8 irq masked by enable", irq_o, 2'b00);
    @(negedge clk); en_i = 2'b11; #1;
    check("R8 irq after enable", irq_o, 2'b01);
    clear(2'b01);

    // R7 set and clear on the same edge
    toggle(12'h002);
    step(3);
    clear(2'b01);
    check("R7 set wins over clear", flag_o, 2'b01);
    clear(2'b01);
    check("R6 clear after collision", flag_o, 2'b00);

    // random rounds
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      mask0_i = 8'($urandom); mask1_i = 4'($urandom); en_i = 2'($urandom);
      t = 12'($urandom);
      if (i % 4 == 0) t = 12'h000;
      e = exp_hit(t, mask0_i, mask1_i);
      toggle(t);
      check("R9 random wake", wake_o, exp_wake(t, mask0_i, mask1_i, en_i));
      step(3);
      check("R5 random not yet", flag_o, 2'b00);
      step(1);
      check("R2 R3 random flags", flag_o, e);
      check("R8 random irq", irq_o, e & en_i);
      clear(2'b11);
      check("R6 random clear", flag_o, 2'b00);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule